// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block gives two ports that share a memory a way to signal each other. Two word addresses at the top of the address space are set aside as mailboxes, and each port owns one of them. When a port writes into the other port's mailbox, the owner's interrupt flag is raised. The owner lowers the flag by reading its own mailbox. The message itself is held in the shared array; this block only sees the access signals.

Each port presents an enable, a write strobe, a read strobe, an address and a busy input that comes from arbitration logic elsewhere. While a port's busy is active, its accesses can neither raise the other side's flag nor clear its own flag. One registered interrupt output is driven for each port.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both `lo_irq` and `hi_irq` read 0.
- R2: With address width W, the low side owns mailbox address 2^W-2 and the high side owns mailbox address 2^W-1.
- R3: A low-side write (`lo_en`=1, `lo_wr`=1) to address 2^W-1 while low-side busy is inactive makes `hi_irq` 1 from the next clock edge onward.
- R4: A high-side write to address 2^W-2 while high-side busy is inactive makes `lo_irq` 1 from the next clock edge onward.
- R5: A read (`en`=1, `rd`=1, `wr`=0) by a side of its own mailbox while its busy is inactive makes that side's irq 0 at the next clock edge, unless R9 applies.
- R6: Accesses with `en`=0, accesses to any non-mailbox address, a side's reads of the other side's mailbox and a side's writes to its own mailbox leave both irq outputs unchanged.
- R7: While a side's busy is active (busy is active-high in the default configuration), its write to the other side's mailbox does not raise the other side's irq.
- R8: While a side's busy is active, its read of its own mailbox does not clear its irq.
- R9: When a set and a clear for the same irq fall in one cycle, the irq is 1 after that edge.
- R10: An access with both `wr`=1 and `rd`=1 counts only as a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_en | input | 1 | Low side access enable |
| lo_wr | input | 1 | Low side write strobe |
| lo_rd | input | 1 | Low side read strobe |
| lo_addr | input | ADDR_W | Low side word address |
| lo_busy | input | 1 | Low side busy from arbitration |
| lo_irq | output | 1 | Interrupt to the low side |
| hi_en | input | 1 | High side access enable |
| hi_wr | input | 1 | High side write strobe |
| hi_rd | input | 1 | High side read strobe |
| hi_addr | input | ADDR_W | High side word address |
| hi_busy | input | 1 | High side busy from arbitration |
| hi_irq | output | 1 | Interrupt to the high side |

## Verification
The two functions that can fall in one cycle are the raising of a flag by the opposite side's write and the clearing of that flag by its owner's read. The bench provokes this by driving both sides together over every combination of strobe pattern, mailbox address and busy level, starting from each of the four flag states. The flag after the edge is judged against an expected value in which the set takes priority and busy cancels only the side that carries it.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

   localparam int NUM_SIDES = 2;

   typedef enum logic {
      SIDE_LO = 1'b0,
      SIDE_HI = 1'b1
   } side_e;

   // events a side's access produces in one cycle
   typedef struct packed {
      logic peer_set;  // writes into the opposite side's mailbox
      logic own_clr;   // reads its own mailbox
   } mbx_evt_t;

endpackage

// File: rtl/mbx_side_decode.sv
module mbx_side_decode
   import mbx_irq_pkg::*;
#(
   parameter int                 ADDR_W    = 15,
   parameter bit                 BUSY_LOW  = 1'b0,
   parameter logic [ADDR_W-1:0]  OWN_ADDR  = '1,
   parameter logic [ADDR_W-1:0]  PEER_ADDR = '0
) (
   input  logic              en,
   input  logic              wr,
   input  logic              rd,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   output mbx_evt_t          evt
);

   logic busy_act;
   logic wr_acc;
   logic rd_acc;
   logic hit_own;
   logic hit_peer;

   generate
      if (BUSY_LOW) begin : g_busy_lo
         assign busy_act = ~busy;
      end else begin : g_busy_hi
         assign busy_act = busy;
      end
   endgenerate

   // a combined write+read strobe is a write
   assign wr_acc   = en & wr;
   assign rd_acc   = en & rd & ~wr;
   assign hit_own  = (addr == OWN_ADDR);
   assign hit_peer = (addr == PEER_ADDR);

   always_comb begin
      evt          = '0;
      evt.peer_set = wr_acc & hit_peer & ~busy_act;
      evt.own_clr  = rd_acc & hit_own  & ~busy_act;
   end

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   logic q_nxt;

   generate
      if (SET_WINS) begin : g_set_pri
         assign q_nxt = set | (q & ~clr);
      end else begin : g_clr_pri
         assign q_nxt = ~clr & (set | q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_nxt;
   end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_irq_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter bit BUSY_LOW = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_en,
   input  logic              lo_wr,
   input  logic              lo_rd,
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic              lo_busy,
   output logic              lo_irq,
   input  logic              hi_en,
   input  logic              hi_wr,
   input  logic              hi_rd,
   input  logic [ADDR_W-1:0] hi_addr,
   input  logic              hi_busy,
   output logic              hi_irq
);

   localparam logic [ADDR_W-1:0] MBX_HI = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] MBX_LO = MBX_HI - 1'b1;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("mbx_irq_ctrl: ADDR_W must lie in 2..32");
      end
   endgenerate

   logic              en_v   [NUM_SIDES];
   logic              wr_v   [NUM_SIDES];
   logic              rd_v   [NUM_SIDES];
   logic              busy_v [NUM_SIDES];
   logic [ADDR_W-1:0] addr_v [NUM_SIDES];
   mbx_evt_t          evt_v  [NUM_SIDES];
   logic              irq_v  [NUM_SIDES];

   assign en_v[SIDE_LO]   = lo_en;
   assign wr_v[SIDE_LO]   = lo_wr;
   assign rd_v[SIDE_LO]   = lo_rd;
   assign busy_v[SIDE_LO] = lo_busy;
   assign addr_v[SIDE_LO] = lo_addr;
   assign en_v[SIDE_HI]   = hi_en;
   assign wr_v[SIDE_HI]   = hi_wr;
   assign rd_v[SIDE_HI]   = hi_rd;
   assign busy_v[SIDE_HI] = hi_busy;
   assign addr_v[SIDE_HI] = hi_addr;

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         localparam int                PEER_IDX = NUM_SIDES - 1 - s;
         localparam logic [ADDR_W-1:0] OWN_A    = (s == 0) ? MBX_LO : MBX_HI;
         localparam logic [ADDR_W-1:0] PEER_A   = (s == 0) ? MBX_HI : MBX_LO;

         mbx_side_decode #(
            .ADDR_W    (ADDR_W),
            .BUSY_LOW  (BUSY_LOW),
            .OWN_ADDR  (OWN_A),
            .PEER_ADDR (PEER_A)
         ) dec_i (
            .en   (en_v[s]),
            .wr   (wr_v[s]),
            .rd   (rd_v[s]),
            .busy (busy_v[s]),
            .addr (addr_v[s]),
            .evt  (evt_v[s])
         );

         // the flag of side s is raised by the other side, lowered by s
         mbx_irq_flag #(
            .SET_WINS (SET_WINS)
         ) flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (evt_v[PEER_IDX].peer_set),
            .clr   (evt_v[s].own_clr),
            .q     (irq_v[s])
         );
      end
   endgenerate

   assign lo_irq = irq_v[SIDE_LO];
   assign hi_irq = irq_v[SIDE_HI];

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
   parameter int ADDR_W   = 15,
   parameter bit BUSY_LOW = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lo_en,
   input logic              lo_wr,
   input logic              lo_rd,
   input logic [ADDR_W-1:0] lo_addr,
   input logic              lo_busy,
   input logic              lo_irq,
   input logic              hi_en,
   input logic              hi_wr,
   input logic              hi_rd,
   input logic [ADDR_W-1:0] hi_addr,
   input logic              hi_busy,
   input logic              hi_irq
);

   localparam logic [ADDR_W-1:0] A_HI = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] A_LO = A_HI - 1'b1;

   logic lo_free, hi_free;
   logic lo_sets_hi, hi_sets_lo, lo_clears, hi_clears;

   assign lo_free    = BUSY_LOW ? lo_busy : ~lo_busy;
   assign hi_free    = BUSY_LOW ? hi_busy : ~hi_busy;
   assign lo_sets_hi = lo_en && lo_wr && (lo_addr == A_HI) && lo_free;
   assign hi_sets_lo = hi_en && hi_wr && (hi_addr == A_LO) && hi_free;
   assign lo_clears  = lo_en && lo_rd && !lo_wr && (lo_addr == A_LO) && lo_free;
   assign hi_clears  = hi_en && hi_rd && !hi_wr && (hi_addr == A_HI) && hi_free;

   p_lo_sets_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lo_sets_hi |=> hi_irq);
   p_hi_sets_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_sets_lo |=> lo_irq);
   p_lo_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lo_clears && !hi_sets_lo |=> !lo_irq);
   p_hi_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hi_clears && !lo_sets_hi |=> !hi_irq);
   p_lo_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_irq && !hi_sets_lo |=> !lo_irq);
   p_hi_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_irq && !lo_sets_hi |=> !hi_irq);
   p_lo_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_free && !hi_sets_lo |=> $stable(lo_irq));
   p_hi_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_free && !lo_sets_hi |=> $stable(hi_irq));

   generate
      if (SET_WINS) begin : g_set_pri_chk
         p_lo_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hi_sets_lo && lo_clears |=> lo_irq);
         p_hi_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
            lo_sets_hi && hi_clears |=> hi_irq);
      end
   endgenerate

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .BUSY_LOW (BUSY_LOW),
   .SET_WINS (SET_WINS)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .lo_en   (lo_en),
   .lo_wr   (lo_wr),
   .lo_rd   (lo_rd),
   .lo_addr (lo_addr),
   .lo_busy (lo_busy),
   .lo_irq  (lo_irq),
   .hi_en   (hi_en),
   .hi_wr   (hi_wr),
   .hi_rd   (hi_rd),
   .hi_addr (hi_addr),
   .hi_busy (hi_busy),
   .hi_irq  (hi_irq)
);

// File: tb/mbx_irq_ctrl_tb_top.sv
module mbx_irq_ctrl_tb_top;

   localparam int AW    = 4;
   localparam int TOP_A = (1 << AW) - 1;   // high side mailbox (R2)
   localparam int SUB_A = (1 << AW) - 2;   // low side mailbox (R2)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic          en_s   [2];
   logic          wr_s   [2];
   logic          rd_s   [2];
   logic          busy_s [2];
   logic [AW-1:0] addr_s [2];
   logic          lo_irq, hi_irq;

   int n_checks = 0;
   int n_fail   = 0;
   logic [1:0] exp_q = 2'b00;   // bit 0 low side, bit 1 high side

   mbx_irq_ctrl #(.ADDR_W(AW)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_en   (en_s[0]),
      .lo_wr   (wr_s[0]),
      .lo_rd   (rd_s[0]),
      .lo_addr (addr_s[0]),
      .lo_busy (busy_s[0]),
      .lo_irq  (lo_irq),
      .hi_en   (en_s[1]),
      .hi_wr   (wr_s[1]),
      .hi_rd   (rd_s[1]),
      .hi_addr (addr_s[1]),
      .hi_busy (busy_s[1]),
      .hi_irq  (hi_irq)
   );

   // op: 0 disabled (wr and rd high), 1 write, 2 read, 3 write and read
   task automatic drive(input int s, input int op, input int ad, input bit bz);
      en_s[s]   = (op != 0);
      wr_s[s]   = (op != 2);
      rd_s[s]   = (op != 1);
      addr_s[s] = ad[AW-1:0];
      busy_s[s] = bz;
   endtask

   task automatic check(input string tag);
      n_checks++;
      if (lo_irq !== exp_q[0] || hi_irq !== exp_q[1]) begin
         n_fail++;
         $display("FAIL %s lo_irq=%0b hi_irq=%0b expected lo=%0b hi=%0b",
                  tag, lo_irq, hi_irq, exp_q[0], exp_q[1]);
      end
   endtask

   // called at a falling edge; drives both sides, checks at the next one
   task automatic run_pair(input int op0, input int a0, input bit b0,
                           input int op1, input int a1, input bit b1,
                           input string tag);
      logic w0, w1, r0, r1, set_lo, set_hi, clr_lo, clr_hi;
      drive(0, op0, a0, b0);
      drive(1, op1, a1, b1);
      w0 = (op0 == 1 || op0 == 3);
      w1 = (op1 == 1 || op1 == 3);
      r0 = (op0 == 2);
      r1 = (op1 == 2);
      set_hi = w0 && a0 == TOP_A && !b0;
      set_lo = w1 && a1 == SUB_A && !b1;
      clr_lo = r0 && a0 == SUB_A && !b0;
      clr_hi = r1 && a1 == TOP_A && !b1;
      exp_q[0] = set_lo | (exp_q[0] & ~clr_lo);
      exp_q[1] = set_hi | (exp_q[1] & ~clr_hi);
      @(negedge clk);
      check(tag);
   endtask

   task automatic set_state(input logic [1:0] st);
      run_pair(2, SUB_A, 1'b0, 2, TOP_A, 1'b0, "R5 prep");
      run_pair(st[1] ? 1 : 0, TOP_A, 1'b0, st[0] ? 1 : 0, SUB_A, 1'b0, "R3/R4 prep");
   endtask

   function automatic string tag_for(int s, int op, int ad, bit bz);
      int own  = s ? TOP_A : SUB_A;
      int peer = s ? SUB_A : TOP_A;
      if (op == 0) return "R6";
      if (op == 3) return "R10";
      if (op == 1 && ad == peer) return bz ? "R7" : (s ? "R2,R4" : "R2,R3");
      if (op == 2 && ad == own)  return bz ? "R8" : "R2,R5";
      return "R6";
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int s = 0; s < 2; s++) drive(s, 0, 0, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_q = 2'b00;
      check("R1 reset");

      // one side acts alone over every address, strobe pattern and busy level
      for (int st = 0; st < 4; st++)
         for (int s = 0; s < 2; s++)
            for (int ad = 0; ad < (1 << AW); ad++)
               for (int op = 0; op < 4; op++)
                  for (int bz = 0; bz < 2; bz++) begin
                     set_state(st[1:0]);
                     if (s == 0)
                        run_pair(op, ad, bz[0], 0, 0, 1'b0, tag_for(0, op, ad, bz[0]));
                     else
                        run_pair(0, 0, 1'b0, op, ad, bz[0], tag_for(1, op, ad, bz[0]));
                  end

      // both sides act in the same cycle on the mailbox addresses (R9)
      for (int st = 0; st < 4; st++)
         for (int m0 = 0; m0 < 16; m0++)
            for (int m1 = 0; m1 < 16; m1++) begin
               set_state(st[1:0]);
               run_pair(m0 % 4, (m0 / 4) % 2 ? TOP_A : SUB_A, m0 >= 8,
                        m1 % 4, (m1 / 4) % 2 ? TOP_A : SUB_A, m1 >= 8,
                        "R9 concurrent");
            end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule